// File: doc/BRIEF.md
# Eight-Pin GPIO Port Controller with Edge Interrupts

This block controls one port of eight general purpose pins through a small word-addressed register bank. Software drives the pins either with a whole-port data write or with set and clear aliases that flip only the bits written as one. This avoids read-modify-write sequences when several agents share the port. Each pin has a 4-bit drive field. Its low three bits pick high-impedance, pull-up, pull-down or strong drive, and its top bit enables the digital input buffer. A per-pin source select hands the output value to a peripheral instead of software.

Pad inputs pass through a two-flop synchronizer and are gated by the input-buffer enable. The synchronized value can be read back and is also forwarded to peripherals. A 2-bit edge selector per pin turns synchronized transitions into sticky status bits, which software clears by writing ones. The OR of the status bits that are unmasked forms the single port interrupt line. The register bank is written with a one-cycle write strobe, and it is read combinationally at the address currently presented.

Top module: `gpio_port_ctrl`

## Requirements
- R1: After synchronous reset, every register reads 0, and `pad_oe`, `pad_pu`, `pad_pd` and `irq` are 0. Every pin is then high-impedance with its input buffer off and is under software control.
- R2: A write to address 0 replaces all eight output data bits in the clock edge that takes the write, and a read of address 0 returns them. With software as the source, `pad_out[n]` equals data bit n.
- R3: A write to address 1 sets only the data bits written as 1, and a write to address 2 clears only the data bits written as 1. All other data bits keep their value, and addresses 1 and 2 read as 0.
- R4: The drive word at address 3 holds pin n in bits [4n+3:4n]. Low-three-bit code 0 is high-Z, 2 is pull-up (`pad_pu`), 3 is pull-down (`pad_pd`) and 6 is strong (`pad_oe`). Any other code behaves as high-Z, and no pin ever has output-enable and a pull active together.
- R5: Bit 4n+3 of the drive word enables pin n's input buffer. A pad change appears in the input value (address 9, and `per_in`) after two clock edges. A pin whose buffer is off reads 0 and never sets a status bit.
- R6: The edge word at address 4 holds pin n in bits [2n+1:2n], where 0 is off, 1 is rising, 2 is falling and 3 is both. A qualifying pad edge sets status bit n three clock edges after the pad changes.
- R7: Status (address 6) is sticky. Writing 1 to a status bit clears it, writing 0 leaves it unchanged, and it holds its value when no edge arrives and no clear is written.
- R8: When an edge is captured for a pin in the same cycle that software clears that pin's status bit, the bit ends up set.
- R9: The mask at address 5 (bit n for pin n) gates the status bits. `irq` is the OR of status AND mask, and address 10 reads status AND mask.
- R10: Address 7 bits [3:0] select the source of pins 3..0, and address 8 bits [3:0] select the source of pins 7..4. A select bit of 1 drives `pad_out[n]` from `per_out[n]`, and 0 drives it from the data register. Addresses not listed read as 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_addr | input | 4 | Word address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| pad_in | input | 8 | Raw pad input levels |
| pad_out | output | 8 | Pad output value |
| pad_oe | output | 8 | Pad output enable (strong drive) |
| pad_pu | output | 8 | Pull-up enable |
| pad_pd | output | 8 | Pull-down enable |
| per_out | input | 8 | Peripheral output values |
| per_in | output | 8 | Synchronized, buffer-gated input to peripherals |
| irq | output | 1 | Combined port interrupt |

## Verification
Two functions can coincide for a status bit: hardware edge capture and the software write-one-to-clear. The bench times a pad transition so that the synchronized edge is detected in exactly the cycle that a status clear of all ones is taken. It then expects only the freshly hit bit to survive. A behavioural reference model advances each clock from the same stimulus. It compares every output, and the read data at the current address, in every cycle, so any slip of a cycle in the capture or clear path shows up as a mismatch.

// File: rtl/gpio_pkg.sv
package gpio_pkg;

    localparam int NPIN    = 8;
    localparam int DM_W    = 4;
    localparam int EG_W    = 2;
    localparam int ADDR_W  = 4;
    localparam int DATA_W  = 32;
    localparam int SRC_GRP = 4;

    localparam logic [ADDR_W-1:0] A_DATA   = 4'd0;
    localparam logic [ADDR_W-1:0] A_SET    = 4'd1;
    localparam logic [ADDR_W-1:0] A_CLR    = 4'd2;
    localparam logic [ADDR_W-1:0] A_DRIVE  = 4'd3;
    localparam logic [ADDR_W-1:0] A_EDGE   = 4'd4;
    localparam logic [ADDR_W-1:0] A_MASK   = 4'd5;
    localparam logic [ADDR_W-1:0] A_STAT   = 4'd6;
    localparam logic [ADDR_W-1:0] A_SRC_LO = 4'd7;
    localparam logic [ADDR_W-1:0] A_SRC_HI = 4'd8;
    localparam logic [ADDR_W-1:0] A_INPUT  = 4'd9;
    localparam logic [ADDR_W-1:0] A_PEND   = 4'd10;

    typedef enum logic [2:0] {
        DRV_HIGHZ  = 3'd0,
        DRV_PULLUP = 3'd2,
        DRV_PULLDN = 3'd3,
        DRV_STRONG = 3'd6
    } drive_code_e;

    typedef enum logic [1:0] {
        EDG_OFF  = 2'd0,
        EDG_RISE = 2'd1,
        EDG_FALL = 2'd2,
        EDG_BOTH = 2'd3
    } edge_sel_e;

    typedef struct packed {
        logic oe;
        logic pu;
        logic pd;
        logic ie;
    } pad_ctl_t;

    function automatic pad_ctl_t decode_drive(input logic [DM_W-1:0] fld);
        pad_ctl_t c;
        c.oe = 1'b0;
        c.pu = 1'b0;
        c.pd = 1'b0;
        c.ie = fld[DM_W-1];
        case (fld[2:0])
            DRV_PULLUP: c.pu = 1'b1;
            DRV_PULLDN: c.pd = 1'b1;
            DRV_STRONG: c.oe = 1'b1;
            default:    ;
        endcase
        return c;
    endfunction

    function automatic logic edge_match(input logic [EG_W-1:0] sel,
                                        input logic prev, input logic cur);
        logic rise;
        logic fall;
        rise = cur & ~prev;
        fall = prev & ~cur;
        case (sel)
            EDG_RISE: return rise;
            EDG_FALL: return fall;
            EDG_BOTH: return rise | fall;
            default:  return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/gpio_in_path.sv
module gpio_in_path
    import gpio_pkg::*;
#(
    parameter int N = NPIN
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [N-1:0]      pad_in,
    input  logic [N-1:0]      ie,
    input  logic [N*EG_W-1:0] edge_cfg,
    output logic [N-1:0]      in_val,
    output logic [N-1:0]      edge_hit
);

    logic [N-1:0] meta_q;
    logic [N-1:0] sync_q;
    logic [N-1:0] prev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta_q <= '0;
            sync_q <= '0;
            prev_q <= '0;
        end else begin
            meta_q <= pad_in;
            sync_q <= meta_q;
            prev_q <= sync_q;
        end
    end

    for (genvar n = 0; n < N; n++) begin : g_pin
        assign in_val[n]   = sync_q[n] & ie[n];
        assign edge_hit[n] = ie[n] &
                             edge_match(edge_cfg[EG_W*n +: EG_W], prev_q[n], sync_q[n]);
    end

    // R5: a pin with its buffer off never produces an event
    a_r5_off_quiet: assert property (@(posedge clk) disable iff (rst)
        ((edge_hit & ~ie) == '0));

    // R5: the input value is zero on every pin whose buffer is off
    a_r5_read_zero: assert property (@(posedge clk) disable iff (rst)
        ((in_val & ~ie) == '0));

endmodule

// File: rtl/gpio_pad_drive.sv
module gpio_pad_drive
    import gpio_pkg::*;
#(
    parameter int N = NPIN
) (
    input  logic [N*DM_W-1:0] drive_cfg,
    input  logic [N-1:0]      data_q,
    input  logic [N-1:0]      per_out,
    input  logic [N-1:0]      src_sel,
    output logic [N-1:0]      pad_out,
    output logic [N-1:0]      pad_oe,
    output logic [N-1:0]      pad_pu,
    output logic [N-1:0]      pad_pd,
    output logic [N-1:0]      ie
);

    for (genvar n = 0; n < N; n++) begin : g_pin
        pad_ctl_t ctl;
        assign ctl        = decode_drive(drive_cfg[DM_W*n +: DM_W]);
        assign pad_oe[n]  = ctl.oe;
        assign pad_pu[n]  = ctl.pu;
        assign pad_pd[n]  = ctl.pd;
        assign ie[n]      = ctl.ie;
        assign pad_out[n] = src_sel[n] ? per_out[n] : data_q[n];
    end

endmodule

// File: rtl/gpio_regbank.sv
module gpio_regbank
    import gpio_pkg::*;
#(
    parameter int N = NPIN
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [N-1:0]      edge_hit,
    input  logic [N-1:0]      in_val,
    output logic [DATA_W-1:0] rdata,
    output logic [N-1:0]      data_q,
    output logic [N*DM_W-1:0] drive_q,
    output logic [N*EG_W-1:0] edge_q,
    output logic [N-1:0]      mask_q,
    output logic [N-1:0]      stat_q,
    output logic [N-1:0]      src_q
);

    localparam int HI_W = N - SRC_GRP;

    logic         clr_wr;
    logic [N-1:0] stat_d;

    assign clr_wr = wr_en && (addr == A_STAT);

    always_comb begin
        stat_d = stat_q;
        if (clr_wr) stat_d = stat_q & ~wdata[N-1:0];
        stat_d = stat_d | edge_hit;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            data_q  <= '0;
            drive_q <= '0;
            edge_q  <= '0;
            mask_q  <= '0;
            stat_q  <= '0;
            src_q   <= '0;
        end else begin
            stat_q <= stat_d;
            if (wr_en) begin
                case (addr)
                    A_DATA:   data_q  <= wdata[N-1:0];
                    A_SET:    data_q  <= data_q | wdata[N-1:0];
                    A_CLR:    data_q  <= data_q & ~wdata[N-1:0];
                    A_DRIVE:  drive_q <= wdata[N*DM_W-1:0];
                    A_EDGE:   edge_q  <= wdata[N*EG_W-1:0];
                    A_MASK:   mask_q  <= wdata[N-1:0];
                    A_SRC_LO: src_q[SRC_GRP-1:0] <= wdata[SRC_GRP-1:0];
                    A_SRC_HI: src_q[N-1:SRC_GRP] <= wdata[HI_W-1:0];
                    default:  ;
                endcase
            end
        end
    end

    always_comb begin
        rdata = '0;
        case (addr)
            A_DATA:   rdata[N-1:0]      = data_q;
            A_DRIVE:  rdata[N*DM_W-1:0] = drive_q;
            A_EDGE:   rdata[N*EG_W-1:0] = edge_q;
            A_MASK:   rdata[N-1:0]      = mask_q;
            A_STAT:   rdata[N-1:0]      = stat_q;
            A_SRC_LO: rdata[SRC_GRP-1:0] = src_q[SRC_GRP-1:0];
            A_SRC_HI: rdata[HI_W-1:0]   = src_q[N-1:SRC_GRP];
            A_INPUT:  rdata[N-1:0]      = in_val;
            A_PEND:   rdata[N-1:0]      = stat_q & mask_q;
            default:  ;
        endcase
    end

    // R3: a set-alias write never lowers a data bit
    a_r3_set_no_drop: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr == A_SET) |=> (($past(data_q) & ~data_q) == '0));

    // R3: a clear-alias write never raises a data bit
    a_r3_clr_no_raise: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr == A_CLR) |=> ((~$past(data_q) & data_q) == '0));

    // R8: a captured edge always lands, even against a clear
    a_r8_edge_wins: assert property (@(posedge clk) disable iff (rst)
        (|edge_hit) |=> ((stat_q & $past(edge_hit)) == $past(edge_hit)));

    // R7: status holds without an event or a clear write
    a_r7_sticky: assert property (@(posedge clk) disable iff (rst)
        (!(|edge_hit) && !clr_wr) |=> $stable(stat_q));

endmodule

// File: rtl/gpio_port_ctrl.sv
module gpio_port_ctrl
    import gpio_pkg::*;
#(
    parameter int N = NPIN
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [N-1:0]      pad_in,
    output logic [N-1:0]      pad_out,
    output logic [N-1:0]      pad_oe,
    output logic [N-1:0]      pad_pu,
    output logic [N-1:0]      pad_pd,
    input  logic [N-1:0]      per_out,
    output logic [N-1:0]      per_in,
    output logic              irq
);

    logic [N-1:0]      data_q;
    logic [N*DM_W-1:0] drive_q;
    logic [N*EG_W-1:0] edge_q;
    logic [N-1:0]      mask_q;
    logic [N-1:0]      stat_q;
    logic [N-1:0]      src_q;
    logic [N-1:0]      ie;
    logic [N-1:0]      in_val;
    logic [N-1:0]      edge_hit;

    gpio_regbank #(.N(N)) u_regs (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (bus_wr),
        .addr     (bus_addr),
        .wdata    (bus_wdata),
        .edge_hit (edge_hit),
        .in_val   (in_val),
        .rdata    (bus_rdata),
        .data_q   (data_q),
        .drive_q  (drive_q),
        .edge_q   (edge_q),
        .mask_q   (mask_q),
        .stat_q   (stat_q),
        .src_q    (src_q)
    );

    gpio_pad_drive #(.N(N)) u_drive (
        .drive_cfg (drive_q),
        .data_q    (data_q),
        .per_out   (per_out),
        .src_sel   (src_q),
        .pad_out   (pad_out),
        .pad_oe    (pad_oe),
        .pad_pu    (pad_pu),
        .pad_pd    (pad_pd),
        .ie        (ie)
    );

    gpio_in_path #(.N(N)) u_in (
        .clk      (clk),
        .rst      (rst),
        .pad_in   (pad_in),
        .ie       (ie),
        .edge_cfg (edge_q),
        .in_val   (in_val),
        .edge_hit (edge_hit)
    );

    assign per_in = in_val;
    assign irq    = |(stat_q & mask_q);

    // R4: output drive and a pull are never on together
    a_r4_no_contend: assert property (@(posedge clk) disable iff (rst)
        ((pad_oe & (pad_pu | pad_pd)) == '0));

    // R9: the interrupt line stays low while every pending bit is masked off
    a_r9_masked_quiet: assert property (@(posedge clk) disable iff (rst)
        ((stat_q & mask_q) == '0) |-> !irq);

endmodule

// File: tb/gpio_port_ctrl_tb.sv
module gpio_port_ctrl_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_wr = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [7:0]  pad_in = '0;
    logic [7:0]  pad_out, pad_oe, pad_pu, pad_pd, per_in;
    logic [7:0]  per_out = '0;
    logic        irq;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;

    always #4 clk = ~clk;

    gpio_port_ctrl u_dut (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in),
        .pad_out(pad_out), .pad_oe(pad_oe), .pad_pu(pad_pu), .pad_pd(pad_pd),
        .per_out(per_out), .per_in(per_in), .irq(irq)
    );

    // behavioural reference state
    logic [7:0]  m_out, m_mask, m_stat, m_src, s1, s2, pv;
    logic [31:0] m_drv;
    logic [15:0] m_edge;

    function automatic logic [7:0] m_ie();
        logic [7:0] r;
        for (int n = 0; n < 8; n++) r[n] = m_drv[4*n+3];
        return r;
    endfunction

    function automatic logic [7:0] m_code(input int code);
        logic [7:0] r;
        for (int n = 0; n < 8; n++) r[n] = (int'(m_drv[4*n +: 3]) == code);
        return r;
    endfunction

    function automatic logic [31:0] m_read(input logic [3:0] a);
        case (a)
            4'd0:  return {24'h0, m_out};
            4'd3:  return m_drv;
            4'd4:  return {16'h0, m_edge};
            4'd5:  return {24'h0, m_mask};
            4'd6:  return {24'h0, m_stat};
            4'd7:  return {28'h0, m_src[3:0]};
            4'd8:  return {28'h0, m_src[7:4]};
            4'd9:  return {24'h0, s2 & m_ie()};
            4'd10: return {24'h0, m_stat & m_mask};
            default: return 32'h0;
        endcase
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_out = 0; m_mask = 0; m_stat = 0; m_src = 0;
            s1 = 0; s2 = 0; pv = 0; m_drv = 0; m_edge = 0;
        end else begin
            logic [7:0] hit;
            for (int n = 0; n < 8; n++) begin
                int sel;
                bit up, dn;
                sel = int'(m_edge[2*n +: 2]);
                up  = s2[n] && !pv[n];
                dn  = !s2[n] && pv[n];
                hit[n] = m_drv[4*n+3] &&
                         ((sel == 1 && up) || (sel == 2 && dn) || (sel == 3 && (up || dn)));
            end
            if (bus_wr) begin
                case (bus_addr)
                    4'd0: m_out = bus_wdata[7:0];
                    4'd1: m_out = m_out | bus_wdata[7:0];
                    4'd2: m_out = m_out & ~bus_wdata[7:0];
                    4'd3: m_drv = bus_wdata;
                    4'd4: m_edge = bus_wdata[15:0];
                    4'd5: m_mask = bus_wdata[7:0];
                    4'd6: m_stat = m_stat & ~bus_wdata[7:0];
                    4'd7: m_src[3:0] = bus_wdata[3:0];
                    4'd8: m_src[7:4] = bus_wdata[3:0];
                    default: ;
                endcase
            end
            m_stat = m_stat | hit;
            pv = s2; s2 = s1; s1 = pad_in;
        end
    end

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    function automatic string addr_tag(input logic [3:0] a);
        case (a)
            4'd0: return "R2";
            4'd1, 4'd2: return "R3";
            4'd3: return "R4";
            4'd4: return "R6";
            4'd5, 4'd10: return "R9";
            4'd6: return "R7";
            4'd9: return "R5";
            default: return "R10";
        endcase
    endfunction

    // cycle-by-cycle comparison against the model
    always begin
        @(negedge clk);
        #1;
        if (!rst && !done) begin
            logic [7:0] exp_out;
            exp_out = (m_src & per_out) | (~m_src & m_out);
            chk(pad_out == exp_out, "R10", "pad_out", {24'h0, pad_out}, {24'h0, exp_out});
            chk(pad_oe == m_code(6), "R4", "pad_oe", {24'h0, pad_oe}, {24'h0, m_code(6)});
            chk(pad_pu == m_code(2), "R4", "pad_pu", {24'h0, pad_pu}, {24'h0, m_code(2)});
            chk(pad_pd == m_code(3), "R4", "pad_pd", {24'h0, pad_pd}, {24'h0, m_code(3)});
            chk(per_in == (s2 & m_ie()), "R5", "per_in", {24'h0, per_in}, {24'h0, s2 & m_ie()});
            chk(irq == |(m_stat & m_mask), "R9", "irq", {31'h0, irq}, {31'h0, |(m_stat & m_mask)});
            chk(bus_rdata == m_read(bus_addr), addr_tag(bus_addr), "rdata",
                bus_rdata, m_read(bus_addr));
        end
    end

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0; bus_wdata = '0;
    endtask

    task automatic rd(input logic [3:0] a, input logic [31:0] exp, input string tag);
        bus_addr = a;
        #2;
        chk(bus_rdata == exp, tag, "read", bus_rdata, exp);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        idle(4);
        rst = 1'b0;
        idle(1);
        // R1: reset state
        for (int a = 0; a < 11; a++) rd(4'(a), 32'h0, "R1");
        chk(pad_oe == 0 && pad_pu == 0 && pad_pd == 0 && !irq, "R1", "pads/irq",
            {pad_oe, pad_pu, pad_pd, 7'h0, irq}, 32'h0);
        idle(1);

        // R2: whole-port write, strong drive
        wr(4'd3, 32'h6666_6666);
        wr(4'd0, 32'h0000_00A5);
        rd(4'd0, 32'hA5, "R2");
        chk(pad_out == 8'hA5 && pad_oe == 8'hFF, "R2", "pad_out/oe",
            {16'h0, pad_out, pad_oe}, 32'h0000_A5FF);
        idle(1);

        // R3: aliases
        wr(4'd1, 32'h0000_000A);
        rd(4'd0, 32'hAF, "R3");
        wr(4'd2, 32'h0000_0081);
        rd(4'd0, 32'h2E, "R3");
        rd(4'd1, 32'h0, "R3");
        rd(4'd2, 32'h0, "R3");
        idle(1);

        // R4: mixed drive codes, including an unlisted one
        wr(4'd3, 32'h0000_5632);
        chk(pad_pu == 8'h01 && pad_pd == 8'h02 && pad_oe == 8'h04, "R4", "mixed drive",
            {8'h0, pad_oe, pad_pu, pad_pd}, 32'h0004_0102);
        idle(1);

        // R5/R6: buffers on pins 3..0 only, edge modes per pin
        wr(4'd3, 32'h0000_8888);
        wr(4'd4, 32'h0000_FF39);
        wr(4'd5, 32'h0000_00FF);
        idle(3);
        pad_in = 8'hFF;
        idle(1);
        rd(4'd9, 32'h00, "R5");
        @(negedge clk);
        rd(4'd9, 32'h0F, "R5");
        idle(2);
        rd(4'd6, 32'h05, "R6");
        chk(irq == 1'b1, "R9", "irq up", {31'h0, irq}, 32'h1);
        pad_in = 8'h00;
        idle(4);
        rd(4'd6, 32'h07, "R6");

        // R7: write-one-to-clear
        wr(4'd6, 32'h0000_0001);
        rd(4'd6, 32'h06, "R7");
        idle(3);
        rd(4'd6, 32'h06, "R7");

        // R9: mask gating
        wr(4'd5, 32'h0);
        chk(irq == 1'b0, "R9", "irq masked", {31'h0, irq}, 32'h0);
        wr(4'd5, 32'h0000_0004);
        rd(4'd10, 32'h04, "R9");
        chk(irq == 1'b1, "R9", "irq unmasked", {31'h0, irq}, 32'h1);

        // R8: clear-all coincides with the edge capture of pin 0
        wr(4'd6, 32'h0000_00FF);
        idle(2);
        pad_in = 8'h01;
        idle(2);
        wr(4'd6, 32'h0000_00FF);
        rd(4'd6, 32'h01, "R8");
        idle(2);

        // R10: source selection split across two registers
        wr(4'd3, 32'h6666_6666);
        wr(4'd0, 32'h0);
        per_out = 8'hFF;
        wr(4'd7, 32'h0000_0005);
        wr(4'd8, 32'h0000_0008);
        rd(4'd7, 32'h5, "R10");
        rd(4'd8, 32'h8, "R10");
        chk(pad_out == 8'h85, "R10", "peripheral bits", {24'h0, pad_out}, 32'h85);
        @(negedge clk);
        per_out = 8'h00;
        wr(4'd0, 32'h0000_00FF);
        chk(pad_out == 8'h7A, "R10", "software bits", {24'h0, pad_out}, 32'h7A);
        rd(4'd11, 32'h0, "R10");
        idle(2);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule